// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block takes one cache maintenance request and turns it into a stream of per-line register writes. Each request names a physical start address, a virtual start address, a byte count and an operation. The target is a cache that is indexed by virtual address and tagged by physical address. The block rounds the range out to whole cache lines, counts the lines, and emits one command write per line on a simple write port. It drives that port with no gaps.

Two addressing modes are selected per request. In the packed mode, every command carries the physical line address with a few virtual index bits folded into its unused low bits. In the split mode, every command write carries the virtual line address and is preceded by a write of the physical address to a separate tag register. A request that covers exactly one page skips the alignment step. In split mode such a request also writes the tag register only once. Flush-type operations hold off completion until the cache reports that its flush engine is idle.

Top module: `lineop_sequencer`

## Requirements
- R1: After reset, reqReady is 1, and wrValid and done are both 0.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from the cycle after acceptance through the one-cycle done pulse, and returns to 1 in the cycle after done.
- R3: The command register depends on reqOp. Operation 4 (instruction invalidate) selects 0x19. Operations 1 (invalidate) and 3 (flush and invalidate), which both have bit 0 set, select 0x4A. Operation 2 (flush) selects 0x4C.
- R4: The number of command writes is ceil((size + paddr mod L) / L), where L is the line length (32 bytes by default). No command is issued for a line past the end of the range.
- R5: The first command uses the start address aligned down to a multiple of L. Each later command advances that address by exactly L.
- R6: In packed mode (reqTagMode = 0), command data is the aligned physical line address with virtual address bits [17:13] ORed into data bits [4:0].
- R7: In split mode (reqTagMode = 1), each line produces a tag write followed in the next cycle by a command write. The tag write carries the physical line address and goes to 0x1E for operation 4, or 0x5C otherwise. The command write carries the virtual line address.
- R8: A request whose size equals the page size (8192 bytes) uses the addresses unaligned and counts ceil(size / L) lines. In split mode it issues a single tag write before the first command and none after.
- R9: For operations 2 and 3, done is withheld while flushBusy is 1. done rises in the cycle after flushBusy is seen low following the last command. For operations 1 and 4, done comes in the cycle right after the last command, whatever the value of flushBusy.
- R10: A request whose line count is zero issues no write, and done is 1 in the cycle after acceptance, even for a flush.
- R11: From the first write of a request to its last write, wrValid is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block is idle and will take a request |
| reqPaddr | input | 32 | Physical start address |
| reqVaddr | input | 32 | Virtual start address |
| reqSize | input | 16 | Range length in bytes |
| reqOp | input | 3 | Operation: 1 invalidate, 2 flush, 3 flush and invalidate, 4 instruction invalidate |
| reqTagMode | input | 1 | 0 packed addressing, 1 split tag/index addressing |
| flushBusy | input | 1 | The cache flush engine is still working |
| wrValid | output | 1 | A register write is presented this cycle |
| wrAddr | output | 12 | Register address of the write |
| wrData | output | 32 | Data of the write |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The hardest cases to reach are the ones at the edge of the range. One is a start offset that pushes a short request into a second line. Another is a size that is an exact multiple of the line, where a loop that runs one step too far would show up. The stimulus sets a start address one byte below a line boundary with sizes 1 and 2. It also sends an aligned range of exactly three lines and a zero-byte request at an unaligned address. The busy wait is reached by holding flushBusy high through every request. It is released only some cycles after the last write of a flush, so the bench also confirms that invalidate-only requests pay no attention to it.

// File: rtl/lineop_pkg.sv
package lineop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_CMD,
    ST_WAIT,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic issueTag;
    logic issueCmd;
  } seqStrobe_t;

  localparam logic [2:0] OP_ICACHE_INV = 3'd4;

endpackage

// File: rtl/lineop_dpath.sv
module lineop_dpath
  import lineop_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 16,
  parameter int REG_W        = 12,
  parameter int LINE_BYTES   = 32,
  parameter int PAGE_BYTES   = 8192,
  parameter int ALIAS_LSB    = 13,
  parameter int ALIAS_W      = 5,
  parameter logic [REG_W-1:0] REG_DINV  = 12'h04A,
  parameter logic [REG_W-1:0] REG_DFLSH = 12'h04C,
  parameter logic [REG_W-1:0] REG_IINV  = 12'h019,
  parameter logic [REG_W-1:0] REG_DTAG  = 12'h05C,
  parameter logic [REG_W-1:0] REG_ITAG  = 12'h01E
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqPaddr,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [2:0]        reqOp,
  input  logic              reqTagMode,
  output logic              newCntZero,
  output logic              lastLine,
  output logic              needWait,
  output logic              tagMode,
  output logic              fullPage,
  output logic [REG_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0] wrData
);

  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int CNT_W      = SIZE_W + 2;
  localparam logic [ADDR_W-1:0] LINE_STEP  = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0]  paddrQ, vaddrQ;
  logic [ALIAS_W-1:0] aliasQ;
  logic [CNT_W-1:0]   cntQ;
  logic [2:0]         opQ;
  logic               tagModeQ, fullQ;

  logic               reqFull;
  logic [CNT_W-1:0]   adjSize, newCnt;
  logic [REG_W-1:0]   cmdReg, tagReg;

  // request-side line count
  always_comb begin
    reqFull = (reqSize == SIZE_W'(PAGE_BYTES));
    adjSize = CNT_W'(reqSize) +
              (reqFull ? '0 : CNT_W'(reqPaddr[LINE_SHIFT-1:0]));
    newCnt  = (adjSize + CNT_W'(LINE_BYTES - 1)) >> LINE_SHIFT;
  end

  assign newCntZero = (newCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddrQ   <= '0;
      vaddrQ   <= '0;
      aliasQ   <= '0;
      cntQ     <= '0;
      opQ      <= '0;
      tagModeQ <= 1'b0;
      fullQ    <= 1'b0;
    end else if (stb.load) begin
      paddrQ   <= reqFull ? reqPaddr : (reqPaddr & ALIGN_MASK);
      vaddrQ   <= reqFull ? reqVaddr : (reqVaddr & ALIGN_MASK);
      aliasQ   <= reqVaddr[ALIAS_LSB +: ALIAS_W];
      cntQ     <= newCnt;
      opQ      <= reqOp;
      tagModeQ <= reqTagMode;
      fullQ    <= reqFull;
    end else if (stb.issueCmd) begin
      paddrQ <= paddrQ + LINE_STEP;
      vaddrQ <= vaddrQ + LINE_STEP;
      cntQ   <= cntQ - CNT_W'(1);
    end
  end

  // register selection by operation
  always_comb begin
    if (opQ == OP_ICACHE_INV) begin
      cmdReg = REG_IINV;
      tagReg = REG_ITAG;
    end else begin
      cmdReg = opQ[0] ? REG_DINV : REG_DFLSH;
      tagReg = REG_DTAG;
    end
  end

  always_comb begin
    wrAddr = stb.issueTag ? tagReg : cmdReg;
    if (stb.issueTag)  wrData = paddrQ;
    else if (tagModeQ) wrData = vaddrQ;
    else               wrData = paddrQ | ADDR_W'(aliasQ);
  end

  assign lastLine = (cntQ == CNT_W'(1));
  assign needWait = (opQ != OP_ICACHE_INV) && opQ[1];
  assign tagMode  = tagModeQ;
  assign fullPage = fullQ;

  // R4: never issue a command once the count is used up
  a_r4_no_extra_line: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueCmd |-> (cntQ != '0));

  // R5: each command moves the line address by one line
  a_r5_line_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueCmd |=> (paddrQ == $past(paddrQ) + LINE_STEP));

endmodule

// File: rtl/lineop_ctrl.sv
module lineop_ctrl
  import lineop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqTagMode,
  input  logic       newCntZero,
  input  logic       lastLine,
  input  logic       needWait,
  input  logic       tagMode,
  input  logic       fullPage,
  input  logic       flushBusy,
  output logic       reqReady,
  output logic       wrValid,
  output logic       done,
  output seqStrobe_t stb
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid)
                 nextState = newCntZero ? ST_DONE : (reqTagMode ? ST_TAG : ST_CMD);
      ST_TAG:  nextState = ST_CMD;
      ST_CMD:  if (lastLine)
                 nextState = needWait ? ST_WAIT : ST_DONE;
               else
                 nextState = (tagMode && !fullPage) ? ST_TAG : ST_CMD;
      ST_WAIT: if (!flushBusy) nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady     = (state == ST_IDLE);
  assign done         = (state == ST_DONE);
  assign stb.load     = (state == ST_IDLE) && reqValid;
  assign stb.issueTag = (state == ST_TAG);
  assign stb.issueCmd = (state == ST_CMD);
  assign wrValid      = stb.issueTag || stb.issueCmd;

  // R2: acceptance closes the request port
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2: done is a single pulse followed by a ready port
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R9: no completion while the flush engine reports busy
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && flushBusy) |=> !done);

endmodule

// File: rtl/lineop_sequencer.sv
module lineop_sequencer
  import lineop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int REG_W      = 12,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int ALIAS_LSB  = 13,
  parameter int ALIAS_W    = 5,
  parameter logic [REG_W-1:0] REG_DINV  = 12'h04A,
  parameter logic [REG_W-1:0] REG_DFLSH = 12'h04C,
  parameter logic [REG_W-1:0] REG_IINV  = 12'h019,
  parameter logic [REG_W-1:0] REG_DTAG  = 12'h05C,
  parameter logic [REG_W-1:0] REG_ITAG  = 12'h01E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqPaddr,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [2:0]        reqOp,
  input  logic              reqTagMode,
  input  logic              flushBusy,
  output logic              wrValid,
  output logic [REG_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0] wrData,
  output logic              done
);

  seqStrobe_t stb;
  logic newCntZero, lastLine, needWait, tagMode, fullPage;

  lineop_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqTagMode (reqTagMode),
    .newCntZero (newCntZero),
    .lastLine   (lastLine),
    .needWait   (needWait),
    .tagMode    (tagMode),
    .fullPage   (fullPage),
    .flushBusy  (flushBusy),
    .reqReady   (reqReady),
    .wrValid    (wrValid),
    .done       (done),
    .stb        (stb)
  );

  lineop_dpath #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .REG_W      (REG_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .ALIAS_LSB  (ALIAS_LSB),
    .ALIAS_W    (ALIAS_W),
    .REG_DINV   (REG_DINV),
    .REG_DFLSH  (REG_DFLSH),
    .REG_IINV   (REG_IINV),
    .REG_DTAG   (REG_DTAG),
    .REG_ITAG   (REG_ITAG)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqPaddr   (reqPaddr),
    .reqVaddr   (reqVaddr),
    .reqSize    (reqSize),
    .reqOp      (reqOp),
    .reqTagMode (reqTagMode),
    .newCntZero (newCntZero),
    .lastLine   (lastLine),
    .needWait   (needWait),
    .tagMode    (tagMode),
    .fullPage   (fullPage),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );

  // R7: a tag write is always followed by a command write
  a_r7_tag_then_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (wrAddr == REG_DTAG || wrAddr == REG_ITAG)) |=>
    (wrValid && wrAddr != REG_DTAG && wrAddr != REG_ITAG));

endmodule

// File: tb/lineop_sequencer_test.sv
module lineop_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqPaddr = '0;
  logic [31:0] reqVaddr = '0;
  logic [15:0] reqSize = '0;
  logic [2:0]  reqOp = '0;
  logic        reqTagMode = 1'b0;
  logic        flushBusy = 1'b0;
  logic        wrValid;
  logic [11:0] wrAddr;
  logic [31:0] wrData;
  logic        done;

  int total = 0;
  int bad = 0;

  logic [11:0] expAddr[$];
  logic [31:0] expData[$];

  always #10 clk = ~clk;

  lineop_sequencer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPaddr(reqPaddr), .reqVaddr(reqVaddr), .reqSize(reqSize),
    .reqOp(reqOp), .reqTagMode(reqTagMode), .flushBusy(flushBusy),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .done(done)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: list of writes a request must produce
  task automatic buildExpected(input logic [31:0] pa, input logic [31:0] va,
                               input logic [15:0] sz, input logic [2:0] op,
                               input logic tm, output int lines);
    logic [31:0] p, v;
    logic [11:0] cmd, tg;
    int unsigned span;
    logic full;
    full = (sz == 16'd8192);
    if (full) begin
      p = pa; v = va; span = sz;
    end else begin
      span = sz + (pa & 32'h1f);
      p = pa & ~32'h1f;
      v = va & ~32'h1f;
    end
    lines = int'((span + 31) / 32);
    cmd = (op == 3'd4) ? 12'h019 : (op[0] ? 12'h04A : 12'h04C);
    tg  = (op == 3'd4) ? 12'h01E : 12'h05C;
    expAddr.delete();
    expData.delete();
    if (!tm) begin
      p = p | ((va >> 13) & 32'h1f);
      for (int i = 0; i < lines; i++) begin
        expAddr.push_back(cmd); expData.push_back(p);
        p = p + 32;
      end
    end else begin
      if (full) begin
        expAddr.push_back(tg); expData.push_back(p);
      end
      for (int i = 0; i < lines; i++) begin
        if (!full) begin
          expAddr.push_back(tg); expData.push_back(p);
        end
        expAddr.push_back(cmd); expData.push_back(v);
        p = p + 32;
        v = v + 32;
      end
    end
  endtask

  task automatic runReq(input logic [31:0] pa, input logic [31:0] va,
                        input logic [15:0] sz, input logic [2:0] op,
                        input logic tm, input int hold, input string dtag);
    int lines;
    logic waits;
    buildExpected(pa, va, sz, op, tm, lines);
    waits = (op == 3'd2 || op == 3'd3) && (lines > 0);
    @(negedge clk);
    check(reqReady == 1'b1, "R2", 32'(reqReady), 32'd1);
    reqPaddr = pa; reqVaddr = va; reqSize = sz; reqOp = op; reqTagMode = tm;
    reqValid = 1'b1;
    flushBusy = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2", 32'(reqReady), 32'd0);
    while (expAddr.size() > 0) begin
      check(wrValid == 1'b1, "R11", 32'(wrValid), 32'd1);
      check(wrAddr == expAddr[0], "R3", 32'(wrAddr), 32'(expAddr[0]));
      check(wrData == expData[0], dtag, wrData, expData[0]);
      check(done == 1'b0, "R4", 32'(done), 32'd0);
      void'(expAddr.pop_front());
      void'(expData.pop_front());
      @(negedge clk);
    end
    if (!waits) begin
      // R9 / R10: completion right after the last write (or acceptance)
      check(done == 1'b1, lines == 0 ? "R10" : "R9", 32'(done), 32'd1);
      check(wrValid == 1'b0, "R4", 32'(wrValid), 32'd0);
    end else begin
      check(done == 1'b0, "R9", 32'(done), 32'd0);
      check(wrValid == 1'b0, "R4", 32'(wrValid), 32'd0);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        check(done == 1'b0, "R9", 32'(done), 32'd0);
      end
      flushBusy = 1'b0;
      @(negedge clk);
      check(done == 1'b1, "R9", 32'(done), 32'd1);
    end
    flushBusy = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1 && done == 1'b0, "R2", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", 32'(reqReady), 32'd1);
    check(wrValid == 1'b0, "R1", 32'(wrValid), 32'd0);
    check(done == 1'b0, "R1", 32'(done), 32'd0);

    // packed mode, unaligned start: three lines, alias bits from vaddr
    runReq(32'h1000_0013, 32'h0002_6010, 16'h0040, 3'd1, 1'b0, 0, "R5/R6");
    // packed mode, exact three-line range, flush waits on busy
    runReq(32'h2000_0040, 32'h0003_E040, 16'h0060, 3'd2, 1'b0, 3, "R6");
    // split mode, flush and invalidate, busy released at once
    runReq(32'h3000_0105, 32'h4000_8125, 16'h0050, 3'd3, 1'b1, 0, "R7");
    // split mode, instruction invalidate, one byte below a boundary
    runReq(32'h0000_001F, 32'h5000_003F, 16'h0001, 3'd4, 1'b1, 0, "R7");
    runReq(32'h0000_001F, 32'h5000_003F, 16'h0002, 3'd4, 1'b1, 0, "R4");
    // full page, split mode: single tag write
    runReq(32'h0004_4000, 32'h7000_6000, 16'd8192, 3'd1, 1'b1, 0, "R8");
    // full page, packed mode, unaligned start kept as given
    runReq(32'h0004_6004, 32'h7000_A000, 16'd8192, 3'd3, 1'b0, 2, "R8");
    // zero lines: aligned zero-size flush
    runReq(32'h0000_0100, 32'h0000_0100, 16'h0000, 3'd2, 1'b0, 0, "R10");
    // zero size but unaligned start still covers one line
    runReq(32'h0000_0104, 32'h0000_4104, 16'h0000, 3'd1, 1'b0, 0, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule